// File: doc/BRIEF.md
# Wire Hit One-Shot Pretrigger

This block watches a plane of anode wire groups arranged as six layers of `NW` wires and decides, crossing by crossing, whether a charged track has started to cross it. Every wire carries a hit strobe that is sampled once per bunch crossing. The block first cleans each wire's strobe. A run of consecutive strobes counts as a single hit. A wire that has just produced a hit stays deaf for a few crossings. A hit that would overrun the readout window is thrown away. Each surviving hit is turned into a one-shot pulse whose length is set by a configuration input.

For every key wire, two slanted envelopes of neighbouring wires are evaluated. One envelope is shaped for beam-halo (accelerator) tracks and the other for collision tracks. The block counts the layers that have at least one pulsing wire inside each envelope. It raises a pretrigger for that key wire when the count reaches the threshold for that envelope. After a pretrigger, the key wire is blocked for a configurable number of crossings. The results are registered: a per-key-wire pretrigger flag, a per-key-wire envelope index, and the crossing number at which the pretrigger happened.

Top module: `wpt_pretrig`

## Requirements
- R1: After a strobe on a wire has been taken as a hit in crossing t, strobes on that wire in crossings t+1 to t+5 are ignored. A fresh strobe in crossing t+6 or later is taken as a new hit.
- R2: A strobe in the crossing directly after a strobe on the same wire is never a new hit, even after the dead period of R1 has run out. A continuously high strobe gives exactly one hit.
- R3: A hit taken in crossing t makes that wire's pulse high in crossings t+1 through t+P. P is `persist_i`, with valid values 1 to 7.
- R4: The crossing counter is 0 in the first crossing after reset, counts up by one per crossing and stops at 31. A hit is discarded (no pulse) when counter + P is 32 or more. A discarded hit still starts the dead period of R1.
- R5: A layer adds at most one to an envelope's layer count, however many of its wires inside the envelope are pulsing.
- R6: A key wire fires in crossing u when an envelope's layer count in u is at least that envelope's 3-bit threshold. `trig_o[k]` is then high during crossing u+1 only. A threshold of 7 can never be met.
- R7: Envelopes, where d is the wire offset from the key wire and layer L runs from 0 to 5: the accelerator envelope takes d in {-1,0} for L<3 and d in {0,+1} for L>=3; the collision envelope takes d in {L/2-1, L/2}. The accelerator envelope is tested first. `trig_pat_o[k]` is 0 for accelerator and 1 for collision, and it is 0 whenever `trig_o[k]` is 0.
- R8: After key wire k fires in crossing u, it cannot fire in crossings u+1 through u+D+E, where D is `drift_i` and E is `extra_dead_i`.
- R9: When any key wire fires in crossing u, `trig_bx_o` shows the counter value of crossing u from crossing u+1 on. It keeps that value until the next firing.
- R10: During and directly after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset; starts a new crossing window |
| hit_i | input | NL*NW | Wire strobes, bit L*NW+w is layer L wire w |
| persist_i | input | 3 | One-shot length P in crossings |
| thr_accel_i | input | 3 | Layer threshold of the accelerator envelope |
| thr_coll_i | input | 3 | Layer threshold of the collision envelope |
| drift_i | input | 2 | Drift part D of the post-fire block |
| extra_dead_i | input | 3 | Extra part E of the post-fire block |
| trig_o | output | NW | Pretrigger flag per key wire |
| trig_pat_o | output | NW | Winning envelope per key wire (0 accelerator, 1 collision) |
| trig_bx_o | output | 5 | Crossing number of the latest firing |

## Verification
The hardest cases to reach from the ports are the ones where the hit filter and the firing logic overlap in time. Examples are a strobe arriving exactly six crossings after an accepted hit, or the same strobe arriving one crossing after a raw strobe; a one-shot being reloaded while its earlier pulse is still high; and a key wire being released from its block in the same crossing that new pulses arrive. Directed sequences place strobes on those exact crossing offsets. The post-fire block is swept over every combination of D and E. A long pseudo-random phase then sweeps every pair of thresholds with varying persistence and block lengths, with enough wire density that pulses overlap and blocks expire while neighbouring wires are still active. A timestamp-based model in the bench predicts every output in every crossing.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  // dead period after a hit, in crossings (R1)
  localparam int DEAD_XINGS = 6;

  localparam int PAT_ACCEL = 0;
  localparam int PAT_COLL  = 1;

  // lowest wire offset of a two-wire envelope slot in a given layer
  function automatic int win_lo(input int pat, input int layer, input int n_layers);
    if (pat == PAT_ACCEL) return (layer < n_layers / 2) ? -1 : 0;
    return layer / 2 - 1;
  endfunction

  function automatic logic in_window(input int pat, input int layer, input int n_layers,
                                     input int delta);
    int lo;
    lo = win_lo(pat, layer, n_layers);
    return (delta >= lo) && (delta <= lo + 1);
  endfunction

  // a hit is usable only if its pulse ends inside the window
  function automatic logic in_range(input int bx, input int persist, input int limit);
    return (bx + persist) < limit;
  endfunction

endpackage

// File: rtl/wpt_wire_shot.sv
module wpt_wire_shot
  import wpt_pkg::*;
#(
  parameter int BX_LIMIT = 32,
  parameter int BXW      = 5,
  parameter int PW       = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit_i,
  input  logic [BXW-1:0] bx_i,
  input  logic [PW-1:0]  persist_i,
  output logic           pulse_o
);

  localparam int DW = $clog2(DEAD_XINGS);

  logic          prev_q;
  logic [DW-1:0] dead_q;
  logic [PW-1:0] shot_q;
  logic          seen_w;
  logic          accept_w;

  // new hit: rising strobe outside the dead period
  assign seen_w   = hit_i && !prev_q && (dead_q == '0);
  assign accept_w = seen_w && in_range(int'(bx_i), int'(persist_i), BX_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      dead_q <= '0;
      shot_q <= '0;
    end else begin
      prev_q <= hit_i;
      if (seen_w)             dead_q <= DW'(DEAD_XINGS - 1);
      else if (dead_q != '0)  dead_q <= dead_q - 1'b1;
      if (accept_w)           shot_q <= persist_i;
      else if (shot_q != '0)  shot_q <= shot_q - 1'b1;
    end
  end

  assign pulse_o = (shot_q != '0);

  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> !$past(accept_w, 1) && !$past(accept_w, 2) && !$past(accept_w, 3)
                 && !$past(accept_w, 4) && !$past(accept_w, 5)); // R1

  AST_RAW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && $past(hit_i)) |-> !accept_w); // R2

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(accept_w)); // R3

endmodule

// File: rtl/wpt_key_eval.sv
module wpt_key_eval
  import wpt_pkg::*;
#(
  parameter int NL  = 6,
  parameter int NW  = 8,
  parameter int KEY = 0,
  parameter int TW  = 3,
  parameter int HW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NL*NW-1:0] pulse_i,
  input  logic [TW-1:0]   thr_acc_i,
  input  logic [TW-1:0]   thr_coll_i,
  input  logic [HW-1:0]   hold_i,
  output logic            fire_o,
  output logic            pat_o
);

  logic [NL-1:0] lay_acc;
  logic [NL-1:0] lay_coll;
  logic          acc_ok;
  logic          coll_ok;
  logic          fire_w;
  logic [HW-1:0] blk_q;

  // one bit per layer: any pulsing wire inside the envelope slot
  always_comb begin
    lay_acc  = '0;
    lay_coll = '0;
    for (int l = 0; l < NL; l++) begin
      for (int w = 0; w < NW; w++) begin
        if (pulse_i[l*NW + w] && in_window(PAT_ACCEL, l, NL, w - KEY)) lay_acc[l]  = 1'b1;
        if (pulse_i[l*NW + w] && in_window(PAT_COLL,  l, NL, w - KEY)) lay_coll[l] = 1'b1;
      end
    end
  end

  assign acc_ok  = $countones(lay_acc)  >= int'(thr_acc_i);
  assign coll_ok = $countones(lay_coll) >= int'(thr_coll_i);
  assign fire_w  = (blk_q == '0) && (acc_ok || coll_ok);

  always_ff @(posedge clk) begin
    if (!rst_n)            blk_q <= '0;
    else if (fire_w)       blk_q <= hold_i;
    else if (blk_q != '0)  blk_q <= blk_q - 1'b1;
  end

  assign fire_o = fire_w;
  assign pat_o  = !acc_ok;

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && hold_i != '0) |=> !fire_w); // R8

endmodule

// File: rtl/wpt_pretrig.sv
module wpt_pretrig
  import wpt_pkg::*;
#(
  parameter int NL       = 6,
  parameter int NW       = 8,
  parameter int BX_LIMIT = 32,
  parameter int PW       = 3,
  parameter int TW       = 3,
  parameter int DW       = 2,
  parameter int XW       = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NL*NW-1:0]            hit_i,
  input  logic [PW-1:0]               persist_i,
  input  logic [TW-1:0]               thr_accel_i,
  input  logic [TW-1:0]               thr_coll_i,
  input  logic [DW-1:0]               drift_i,
  input  logic [XW-1:0]               extra_dead_i,
  output logic [NW-1:0]               trig_o,
  output logic [NW-1:0]               trig_pat_o,
  output logic [$clog2(BX_LIMIT)-1:0] trig_bx_o
);

  localparam int BXW = $clog2(BX_LIMIT);
  localparam int HW  = ((DW > XW) ? DW : XW) + 1;

  logic [BXW-1:0]   bx_q;
  logic [NL*NW-1:0] pulse_w;
  logic [NW-1:0]    fire_w;
  logic [NW-1:0]    pat_w;
  logic [HW-1:0]    hold_w;

  assign hold_w = HW'(drift_i) + HW'(extra_dead_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                           bx_q <= '0;
    else if (bx_q != BXW'(BX_LIMIT - 1))  bx_q <= bx_q + 1'b1;
  end

  for (genvar l = 0; l < NL; l++) begin : g_layer
    for (genvar w = 0; w < NW; w++) begin : g_wire
      wpt_wire_shot #(.BX_LIMIT(BX_LIMIT), .BXW(BXW), .PW(PW)) u_shot (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit_i[l*NW + w]),
        .bx_i     (bx_q),
        .persist_i(persist_i),
        .pulse_o  (pulse_w[l*NW + w])
      );
    end
  end

  for (genvar k = 0; k < NW; k++) begin : g_key
    wpt_key_eval #(.NL(NL), .NW(NW), .KEY(k), .TW(TW), .HW(HW)) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_i   (pulse_w),
      .thr_acc_i (thr_accel_i),
      .thr_coll_i(thr_coll_i),
      .hold_i    (hold_w),
      .fire_o    (fire_w[k]),
      .pat_o     (pat_w[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_o     <= '0;
      trig_pat_o <= '0;
      trig_bx_o  <= '0;
    end else begin
      trig_o     <= fire_w;
      trig_pat_o <= fire_w & pat_w;
      if (|fire_w) trig_bx_o <= bx_q;
    end
  end

  AST_BX_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_o) |-> (trig_bx_o == $past(bx_q))); // R9

endmodule

// File: tb/test_wpt_pretrig.sv
module test_wpt_pretrig;

  localparam int  NL = 6;
  localparam int  NW = 8;
  localparam int  LIM = 32;
  localparam time CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL*NW-1:0] hit_i = '0;
  logic [2:0]      persist_i = 3'd1;
  logic [2:0]      thr_accel_i = 3'd1;
  logic [2:0]      thr_coll_i = 3'd1;
  logic [1:0]      drift_i = '0;
  logic [2:0]      extra_dead_i = '0;
  logic [NW-1:0]   trig_o;
  logic [NW-1:0]   trig_pat_o;
  logic [4:0]      trig_bx_o;

  wpt_pretrig i_wpt_pretrig (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .persist_i(persist_i),
    .thr_accel_i(thr_accel_i), .thr_coll_i(thr_coll_i), .drift_i(drift_i),
    .extra_dead_i(extra_dead_i), .trig_o(trig_o), .trig_pat_o(trig_pat_o),
    .trig_bx_o(trig_bx_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int u;
  int seen_t [NL][NW];
  int acc_t  [NL][NW];
  int acc_p  [NL][NW];
  bit raw_prev [NL][NW];
  int blk_until [NW];
  bit ex_trig [NW];
  bit ex_pat  [NW];
  int ex_bx;
  logic [31:0] lfsr = 32'h1d2c_3b4a;
  string tag;

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog R10: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  function automatic bit acc_win(int l, int d);
    if (l < NL/2) return (d == -1) || (d == 0);
    return (d == 0) || (d == 1);
  endfunction

  function automatic bit col_win(int l, int d);
    return (d - l/2 == -1) || (d - l/2 == 0);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    hit_i = '0;
    repeat (3) @(negedge clk);
    for (int l = 0; l < NL; l++)
      for (int w = 0; w < NW; w++) begin
        seen_t[l][w] = -100; acc_t[l][w] = -1; acc_p[l][w] = 0; raw_prev[l][w] = 0;
      end
    for (int k = 0; k < NW; k++) begin
      blk_until[k] = -1; ex_trig[k] = 0; ex_pat[k] = 0;
    end
    ex_bx = 0;
    u = 0;
    rst_n = 1'b1;
  endtask

  // predict the outputs caused by crossing u with strobes h
  task automatic model(input logic [NL*NW-1:0] h);
    int bx;
    bit anyf;
    bx = (u < LIM) ? u : LIM - 1;
    anyf = 0;
    for (int k = 0; k < NW; k++) begin
      ex_trig[k] = 0;
      ex_pat[k] = 0;
      if (u > blk_until[k]) begin
        int ca, cc;
        ca = 0; cc = 0;
        for (int l = 0; l < NL; l++) begin
          bit ha, hc;
          ha = 0; hc = 0;
          for (int w = 0; w < NW; w++) begin
            bit on;
            on = (acc_t[l][w] >= 0) && (u > acc_t[l][w]) && (u <= acc_t[l][w] + acc_p[l][w]);
            if (on && acc_win(l, w - k)) ha = 1;
            if (on && col_win(l, w - k)) hc = 1;
          end
          ca += ha; cc += hc;
        end
        if (ca >= int'(thr_accel_i)) ex_trig[k] = 1;
        else if (cc >= int'(thr_coll_i)) begin ex_trig[k] = 1; ex_pat[k] = 1; end
        if (ex_trig[k]) begin
          blk_until[k] = u + int'(drift_i) + int'(extra_dead_i);
          anyf = 1;
        end
      end
    end
    if (anyf) ex_bx = bx;
    for (int l = 0; l < NL; l++)
      for (int w = 0; w < NW; w++) begin
        if (h[l*NW + w] && !raw_prev[l][w] && (u - seen_t[l][w] >= 6)) begin
          seen_t[l][w] = u;
          if (bx + int'(persist_i) < LIM) begin
            acc_t[l][w] = u;
            acc_p[l][w] = int'(persist_i);
          end
        end
        raw_prev[l][w] = h[l*NW + w];
      end
    u++;
  endtask

  task automatic step(input logic [NL*NW-1:0] h);
    string t;
    t = (u == 0) ? "R10" : tag;
    for (int k = 0; k < NW; k++) begin
      n_vec++;
      if (trig_o[k] !== ex_trig[k] || trig_pat_o[k] !== ex_pat[k]) begin
        n_bad++;
        $display("FAIL %s xing %0d key %0d: actual trig=%b pat=%b expected trig=%b pat=%b",
                 t, u, k, trig_o[k], trig_pat_o[k], ex_trig[k], ex_pat[k]);
      end
    end
    n_vec++;
    if (trig_bx_o !== 5'(ex_bx)) begin
      n_bad++;
      $display("FAIL %s xing %0d: actual trig_bx=%0d expected %0d",
               (u == 0) ? "R10" : "R9", u, trig_bx_o, ex_bx);
    end
    hit_i = h;
    model(h);
    @(negedge clk);
  endtask

  function automatic logic [NL*NW-1:0] one(int l, int w);
    logic [NL*NW-1:0] v;
    v = '0;
    v[l*NW + w] = 1'b1;
    return v;
  endfunction

  task automatic run(input int ph, input int ta, input int tc, input int p,
                     input int d, input int e, input int n, input string tg);
    thr_accel_i = 3'(ta); thr_coll_i = 3'(tc); persist_i = 3'(p);
    drift_i = 2'(d); extra_dead_i = 3'(e);
    tag = tg;
    do_reset();
    for (int c = 0; c < n; c++) begin
      logic [NL*NW-1:0] h;
      h = '0;
      case (ph)
        0: begin  // R1 R2: runs, dead period edges
          if ((c >= 2 && c <= 9) || c == 15 || c == 20 || c == 21 || c == 27) h |= one(0, 3);
          if (c == 5 || c == 11) h |= one(3, 6);
          if (c == 13 || c == 18 || c == 19) h |= one(5, 1);
        end
        1: if (c == 4) h = one(2, p);                               // R3
        2: begin                                                     // R4
          if (c == 26) h |= one(0, 1);
          if (c == 27) h |= one(0, 5);
          if (c == 31 || c == 40) h |= one(4, 2);
          if (c == 33) h |= one(0, 5);
        end
        3: begin                                                     // R5
          if (c == 3) h = one(1, 2) | one(1, 3) | one(1, 4);
          if (c == 12) h = one(1, 3) | one(2, 3);
        end
        4: begin                                                     // R7
          if (c == 3) h = one(0, 4) | one(1, 4) | one(2, 4) | one(3, 4);
          if (c == 12) h = one(2, 5) | one(3, 5) | one(4, 5) | one(5, 5);
        end
        5: if (c == 2) h = one(0, 2);                               // R8
        default: begin                                               // R6 random
          for (int b = 0; b < NL*NW; b++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            h[b] = (lfsr[1:0] == 2'b00);
          end
        end
      endcase
      step(h);
    end
    step('0);
  endtask

  initial begin
    run(0, 1, 7, 2, 0, 0, 34, "R1/R2");
    for (int p = 1; p <= 7; p++) run(1, 1, 7, p, 0, 0, 16, "R3");
    run(2, 1, 7, 5, 0, 0, 45, "R4");
    run(3, 2, 2, 4, 0, 0, 22, "R5");
    run(3, 1, 7, 4, 0, 0, 22, "R5");
    run(4, 4, 3, 3, 0, 0, 22, "R7");
    run(4, 3, 3, 3, 1, 0, 22, "R7");
    for (int d = 0; d < 4; d++)
      for (int e = 0; e < 8; e++) run(5, 1, 7, 7, d, e, 14, "R8");
    for (int ta = 1; ta <= 7; ta++)
      for (int tc = 1; tc <= 7; tc++)
        run(6, ta, tc, 1 + (ta * tc) % 7, (ta + tc) % 4, (ta * 3 + tc) % 8, 36, "R6");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule